// File: doc/BRIEF.md
# Host Bus Register Interface

This block connects an external microprocessor bus to an internal register space, acting as the bus slave. The host presents a 21-bit address, 16 bits of data with one even-parity bit per byte, and three active-low strobes: address, data and read/write. The address is held by a transparent latch that is open while the address strobe is low. The block forwards each access to an internal register port that uses a request/ready handshake, so each target can take a different number of cycles. Once ready has been seen, it pulls the open-drain acknowledge low. The acknowledge is released at the same moment the host raises the address strobe.

A mode input selects between two timings. In synchronous mode the strobes are taken as already aligned to the local clock. In asynchronous mode they first pass through a two-stage synchronizer. In both modes one qualified falling edge of the combined strobes launches exactly one internal access. A write whose parity does not match never reaches the register port. It is still acknowledged, and it sets a sticky parity-error flag.

The block also collects three groups of sticky, maskable interrupt sources. These drive a high-priority output, a low-priority output and a protection-switch output, each open-drain and active-low. The parity-error flag also drives the low-priority output.

Top module: `hbus_regif`

## Requirements
- R1: After reset the acknowledge and all three interrupt outputs are released (high impedance), no register request is raised, read data is not driven and the parity-error flag is 0.
- R2: The register address equals the bus address present while the address strobe is low, and it holds that value after the strobe rises, even when the bus address then changes.
- R3: In synchronous mode the register request rises on the second rising edge after both strobes go low. It stays high until ready is sampled, and the acknowledge goes low on that same edge. With L wait cycles this is 3+L edges from the strobes to the acknowledge.
- R4: In asynchronous mode each step takes one extra edge, giving 4+L edges from the strobes to the acknowledge.
- R5: One strobe cycle produces exactly one register transfer. Holding the strobes low after the acknowledge raises no further request, and the acknowledge stays low.
- R6: A read (read/write strobe high) returns the register data on the data output, with the enable high while acknowledged. Parity bit 1 is the XOR of data bits 15:8 and parity bit 0 is the XOR of bits 7:0 (even parity). Bits 7:0 form the lower-addressed byte.
- R7: A write (read/write strobe low) with correct even parity raises a request with write enable set and the bus write data, and is acknowledged after 3+L edges in synchronous mode.
- R8: A write with a parity mismatch raises no request. It is acknowledged 2 edges after the strobes in synchronous mode, sets the sticky parity-error flag and pulls the low-priority interrupt low. A parity-clear pulse releases both.
- R9: The acknowledge returns to high impedance in the same time step as the rising edge of the address strobe.
- R10: Each interrupt source bit is sticky from the edge after its pulse until its clear bit is pulsed. Each output is pulled low while any sticky bit of its own group has its mask bit set, and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| async_mode | input | 1 | 1 selects two-stage strobe synchronization |
| bus_addr | input | 21 | Host address, bit 20 MSB |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| bus_rw_n | input | 1 | 1 = read, 0 = write |
| bus_data_in | input | 16 | Write data from host |
| bus_data_out | output | 16 | Read data to host |
| bus_data_oe | output | 1 | Read data drive enable |
| bus_par_in | input | 2 | Even parity of write data, one bit per byte |
| bus_par_out | output | 2 | Even parity of read data, one bit per byte |
| bus_ack_n | output | 1 | Open-drain transfer acknowledge |
| reg_req | output | 1 | Register port request |
| reg_we | output | 1 | Register port write enable |
| reg_addr | output | 21 | Register port address (latched) |
| reg_wdata | output | 16 | Register port write data |
| reg_rdata | input | 16 | Register port read data |
| reg_rdy | input | 1 | Register port ready |
| hp_src | input | 4 | High-priority event pulses |
| hp_mask | input | 4 | High-priority enables |
| hp_clr | input | 4 | High-priority sticky clear |
| lp_src | input | 4 | Low-priority event pulses |
| lp_mask | input | 4 | Low-priority enables |
| lp_clr | input | 4 | Low-priority sticky clear |
| ps_src | input | 2 | Protection-switch event pulses |
| ps_mask | input | 2 | Protection-switch enables |
| ps_clr | input | 2 | Protection-switch sticky clear |
| par_err | output | 1 | Sticky write parity error |
| par_err_clr | input | 1 | Clears the parity error |
| hp_irq_n | output | 1 | Open-drain high-priority interrupt |
| lp_irq_n | output | 1 | Open-drain low-priority interrupt |
| ps_irq_n | output | 1 | Open-drain protection-switch interrupt |

## Verification
Edges are counted from the strobes going low. In synchronous mode the acknowledge is due 3+L rising edges later for reads and for good writes, and 2 edges later for a write with bad parity. In asynchronous mode a read takes 4+L edges, and in every case the acknowledge is released in the same time step as the address strobe rises. The bench starts each access just after a falling edge, then steps one rising edge at a time and samples 1 time unit after each edge, so the edge count at which the acknowledge first reads low is compared exactly with these figures. Read data and parity are sampled on the falling edge after that. A sticky interrupt is due one edge after its pulse, and is checked on the falling edge after the pulse.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2
  } acc_state_t;
endpackage

// File: rtl/hbus_strobe_qual.sv
// Strobe qualification: samples strobes, picks one or SYNC_N stages
// by mode, emits one start pulse per combined-strobe falling edge.
module hbus_strobe_qual #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_mode,
  input  logic as_n,
  input  logic ds_n,
  output logic start,
  output logic as_idle
);
  localparam int LAST = SYNC_N - 1;

  logic [SYNC_N-1:0] as_sr, ds_sr;
  logic as_sel, ds_sel, act, act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_sr <= '1;
      ds_sr <= '1;
      act_d <= 1'b0;
    end else begin
      as_sr <= {as_sr[SYNC_N-2:0], as_n};
      ds_sr <= {ds_sr[SYNC_N-2:0], ds_n};
      act_d <= act;
    end
  end

  always_comb begin
    as_sel  = async_mode ? as_sr[LAST] : as_sr[0];
    ds_sel  = async_mode ? ds_sr[LAST] : ds_sr[0];
    act     = !as_sel && !ds_sel;
    start   = act && !act_d;
    as_idle = as_sel;
  end
endmodule

// File: rtl/hbus_access_ctrl.sv
// Access sequencer: launches a register transfer, waits for ready,
// holds the acknowledge until the qualified address strobe rises.
module hbus_access_ctrl import hbus_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              as_idle,
  input  logic              is_read,
  input  logic              par_ok,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              reg_req,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_rdy,
  output logic              ack_on,
  output logic              rd_on,
  output logic [DATA_W-1:0] rdata_hold,
  output logic              par_fail
);
  acc_state_t        state, state_n;
  logic              rd_q, ld_cmd, ld_rd;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_comb begin
    state_n  = state;
    ld_cmd   = 1'b0;
    ld_rd    = 1'b0;
    par_fail = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        ld_cmd = 1'b1;
        if (!is_read && !par_ok) begin
          par_fail = 1'b1;
          state_n  = ST_ACK;
        end else begin
          state_n  = ST_REQ;
        end
      end
      ST_REQ: if (reg_rdy) begin
        ld_rd   = rd_q;
        state_n = ST_ACK;
      end
      ST_ACK: if (as_idle) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state <= state_n;
      if (ld_cmd) begin
        rd_q    <= is_read;
        wdata_q <= wdata_in;
      end
      if (ld_rd) rdata_q <= reg_rdata;
    end
  end

  always_comb begin
    reg_req    = (state == ST_REQ);
    reg_we     = reg_req && !rd_q;
    reg_wdata  = wdata_q;
    ack_on     = (state == ST_ACK);
    rd_on      = rd_q;
    rdata_hold = rdata_q;
  end
endmodule

// File: rtl/hbus_irq_group.sv
// One interrupt group: sticky source bits, set has priority over clear.
module hbus_irq_group #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] clr,
  output logic         act
);
  logic [W-1:0] sticky, sticky_n;

  always_comb begin
    sticky_n = (sticky & ~clr) | src;
    act      = |(sticky & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= sticky_n;
  end
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif import hbus_pkg::*; #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int HP_W   = 4,
  parameter int LP_W   = 4,
  parameter int PS_W   = 2,
  parameter int SYNC_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                async_mode,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_as_n,
  input  logic                bus_ds_n,
  input  logic                bus_rw_n,
  input  logic [DATA_W-1:0]   bus_data_in,
  output logic [DATA_W-1:0]   bus_data_out,
  output logic                bus_data_oe,
  input  logic [DATA_W/8-1:0] bus_par_in,
  output logic [DATA_W/8-1:0] bus_par_out,
  output logic                bus_ack_n,
  output logic                reg_req,
  output logic                reg_we,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   reg_rdata,
  input  logic                reg_rdy,
  input  logic [HP_W-1:0]     hp_src,
  input  logic [HP_W-1:0]     hp_mask,
  input  logic [HP_W-1:0]     hp_clr,
  input  logic [LP_W-1:0]     lp_src,
  input  logic [LP_W-1:0]     lp_mask,
  input  logic [LP_W-1:0]     lp_clr,
  input  logic [PS_W-1:0]     ps_src,
  input  logic [PS_W-1:0]     ps_mask,
  input  logic [PS_W-1:0]     ps_clr,
  output logic                par_err,
  input  logic                par_err_clr,
  output logic                hp_irq_n,
  output logic                lp_irq_n,
  output logic                ps_irq_n
);
  localparam int NBYTE = DATA_W / 8;

  logic [1:0]        rst_pipe;
  logic              rst_q;
  logic [ADDR_W-1:0] addr_lat;
  logic [NBYTE-1:0]  par_calc_in;
  logic              start, as_idle, par_ok, par_fail, par_err_q;
  logic              ack_on, rd_on, hp_act, lp_act, ps_act;
  logic [DATA_W-1:0] rdata_hold;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // address latch, open while the address strobe is low
  always_latch begin
    if (!bus_as_n) addr_lat = bus_addr;
  end
  assign reg_addr = addr_lat;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign par_calc_in[b] = ^bus_data_in[8*b +: 8];
    assign bus_par_out[b] = ^rdata_hold[8*b +: 8];
  end
  assign par_ok = (par_calc_in == bus_par_in);

  hbus_strobe_qual #(.SYNC_N(SYNC_N)) u_qual (
    .clk(clk), .rst_n(rst_q), .async_mode(async_mode),
    .as_n(bus_as_n), .ds_n(bus_ds_n), .start(start), .as_idle(as_idle)
  );

  hbus_access_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q), .start(start), .as_idle(as_idle),
    .is_read(bus_rw_n), .par_ok(par_ok), .wdata_in(bus_data_in),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rdy(reg_rdy), .ack_on(ack_on),
    .rd_on(rd_on), .rdata_hold(rdata_hold), .par_fail(par_fail)
  );

  hbus_irq_group #(.W(HP_W)) u_hp (
    .clk(clk), .rst_n(rst_q), .src(hp_src), .mask(hp_mask), .clr(hp_clr), .act(hp_act)
  );
  hbus_irq_group #(.W(LP_W)) u_lp (
    .clk(clk), .rst_n(rst_q), .src(lp_src), .mask(lp_mask), .clr(lp_clr), .act(lp_act)
  );
  hbus_irq_group #(.W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_q), .src(ps_src), .mask(ps_mask), .clr(ps_clr), .act(ps_act)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)           par_err_q <= 1'b0;
    else if (par_fail)    par_err_q <= 1'b1;
    else if (par_err_clr) par_err_q <= 1'b0;
  end
  assign par_err = par_err_q;

  assign bus_data_out = rdata_hold;
  assign bus_data_oe  = ack_on && rd_on;

  // open-drain emulation: pull low when active, float otherwise
  assign bus_ack_n = (ack_on && !bus_as_n) ? 1'b0 : 1'bz;
  assign hp_irq_n  = hp_act ? 1'b0 : 1'bz;
  assign lp_irq_n  = (lp_act || par_err_q) ? 1'b0 : 1'bz;
  assign ps_irq_n  = ps_act ? 1'b0 : 1'bz;
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk #(
  parameter int HP_W = 4
) (
  input logic            clk,
  input logic            rst_q,
  input logic            reg_req,
  input logic            reg_rdy,
  input logic            ack_on,
  input logic            par_err,
  input logic [HP_W-1:0] hp_src,
  input logic [HP_W-1:0] hp_mask,
  input logic            hp_act
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_req && !reg_rdy) |=> reg_req);

  assert_ack_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_req && reg_rdy) |=> ack_on);

  assert_single_transfer_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_req && reg_rdy) |=> !reg_req);

  assert_parerr_no_req_R8: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(par_err) |-> (!reg_req && $past(!reg_req)));

  assert_hp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (|(hp_src & hp_mask)) |=> hp_act);
endmodule

bind hbus_regif hbus_regif_chk #(.HP_W(HP_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .reg_req(reg_req), .reg_rdy(reg_rdy),
  .ack_on(ack_on), .par_err(par_err), .hp_src(hp_src),
  .hp_mask(hp_mask), .hp_act(hp_act)
);

// File: tb/hbus_regif_tb.sv
`timescale 1ns/1ps
module hbus_regif_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, async_mode;
  logic [20:0] bus_addr;
  logic        bus_as_n, bus_ds_n, bus_rw_n;
  logic [15:0] bus_data_in, bus_data_out;
  logic        bus_data_oe;
  logic [1:0]  bus_par_in, bus_par_out;
  logic        reg_req, reg_we, reg_rdy;
  logic [20:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [3:0]  hp_src, hp_mask, hp_clr, lp_src, lp_mask, lp_clr;
  logic [1:0]  ps_src, ps_mask, ps_clr;
  logic        par_err, par_err_clr;
  wire         ack_w, hp_w, lp_w, ps_w;
  pullup (ack_w);
  pullup (hp_w);
  pullup (lp_w);
  pullup (ps_w);

  int checks = 0;
  int errors = 0;
  int lat_cfg = 0;
  int wait_cnt = 0;
  int xfer_cnt = 0;
  logic [20:0] seen_addr;
  logic [15:0] seen_wdata;
  logic        seen_we;

  always #(CLK_P/2) clk = ~clk;

  hbus_regif u_dut (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .bus_addr(bus_addr),
    .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_rw_n(bus_rw_n),
    .bus_data_in(bus_data_in), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_par_in(bus_par_in), .bus_par_out(bus_par_out), .bus_ack_n(ack_w),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rdy(reg_rdy),
    .hp_src(hp_src), .hp_mask(hp_mask), .hp_clr(hp_clr),
    .lp_src(lp_src), .lp_mask(lp_mask), .lp_clr(lp_clr),
    .ps_src(ps_src), .ps_mask(ps_mask), .ps_clr(ps_clr),
    .par_err(par_err), .par_err_clr(par_err_clr),
    .hp_irq_n(hp_w), .lp_irq_n(lp_w), .ps_irq_n(ps_w)
  );

  // register port model: ready after lat_cfg wait cycles
  assign reg_rdy   = reg_req && (wait_cnt == lat_cfg);
  assign reg_rdata = reg_addr[15:0] ^ 16'h5A3C;

  always @(posedge clk) begin
    if (reg_req && !reg_rdy) wait_cnt <= wait_cnt + 1;
    else                     wait_cnt <= 0;
    if (reg_req && reg_rdy) begin
      xfer_cnt   <= xfer_cnt + 1;
      seen_addr  <= reg_addr;
      seen_we    <= reg_we;
      seen_wdata <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start(input bit wr, input logic [20:0] a, input logic [15:0] d,
                           input logic [1:0] p, output int edges);
    @(negedge clk);
    bus_addr = a; bus_rw_n = !wr; bus_data_in = d; bus_par_in = p;
    bus_as_n = 1'b0; bus_ds_n = 1'b0;
    edges = 0;
    while (ack_w !== 1'b0 && edges < 60) begin
      @(posedge clk); #1;
      edges++;
    end
  endtask

  task automatic bus_end();
    @(negedge clk);
    bus_as_n = 1'b1; bus_ds_n = 1'b1;
    #1;
    chk(ack_w === 1'b1, "R9 ack release with strobe", ack_w, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ack_w === 1'b1 && hp_w === 1'b1 && lp_w === 1'b1 && ps_w === 1'b1,
        "R1 outputs released", {ack_w, hp_w, lp_w, ps_w}, 4'hF);
    chk(reg_req == 1'b0 && bus_data_oe == 1'b0 && par_err == 1'b0,
        "R1 idle state", {reg_req, bus_data_oe, par_err}, 0);
  endtask

  task automatic t_read(input bit amode, input int lat, input logic [20:0] a);
    int e;
    logic [15:0] exp_d;
    async_mode = amode; lat_cfg = lat;
    exp_d = a[15:0] ^ 16'h5A3C;
    bus_start(1'b0, a, 16'h0, 2'b00, e);
    if (amode) chk(e == 4 + lat, "R4 async read latency", e, 4 + lat);
    else       chk(e == 3 + lat, "R3 sync read latency", e, 3 + lat);
    @(negedge clk);
    chk(bus_data_oe == 1'b1 && bus_data_out == exp_d, "R6 read data", bus_data_out, exp_d);
    chk(bus_par_out == {^exp_d[15:8], ^exp_d[7:0]}, "R6 read parity",
        bus_par_out, {^exp_d[15:8], ^exp_d[7:0]});
    chk(seen_addr == a && seen_we == 1'b0, "R2 request address", seen_addr, a);
    bus_end();
    bus_addr = ~a;
    #1;
    chk(reg_addr == a, "R2 latch holds after strobe", reg_addr, a);
  endtask

  task automatic t_write_good(input int lat, input logic [20:0] a, input logic [15:0] d);
    int e;
    async_mode = 1'b0; lat_cfg = lat;
    bus_start(1'b1, a, d, {^d[15:8], ^d[7:0]}, e);
    chk(e == 3 + lat, "R7 write latency", e, 3 + lat);
    @(negedge clk);
    chk(seen_we == 1'b1 && seen_wdata == d && seen_addr == a, "R7 write data", seen_wdata, d);
    chk(bus_data_oe == 1'b0, "R7 no drive on write", bus_data_oe, 0);
    bus_end();
  endtask

  task automatic t_write_bad();
    int e, n0;
    logic [15:0] d;
    d = 16'h1234;
    async_mode = 1'b0; lat_cfg = 0; n0 = xfer_cnt;
    bus_start(1'b1, 21'h0_0400, d, {^d[15:8], ~^d[7:0]}, e);
    chk(e == 2, "R8 bad parity ack latency", e, 2);
    @(negedge clk);
    chk(xfer_cnt == n0 && reg_req == 1'b0, "R8 no request", xfer_cnt - n0, 0);
    chk(par_err == 1'b1 && lp_w === 1'b0, "R8 flag and lp irq", {par_err, lp_w}, 2'b10);
    bus_end();
    par_err_clr = 1'b1;
    @(negedge clk);
    par_err_clr = 1'b0;
    chk(par_err == 1'b0 && lp_w === 1'b1, "R8 cleared", {par_err, lp_w}, 2'b01);
  endtask

  task automatic t_hold();
    int e, n0;
    async_mode = 1'b1; lat_cfg = 1; n0 = xfer_cnt;
    bus_start(1'b0, 21'h1_2345, 16'h0, 2'b00, e);
    repeat (8) @(negedge clk);
    chk(xfer_cnt - n0 == 1 && reg_req == 1'b0, "R5 single transfer", xfer_cnt - n0, 1);
    chk(ack_w === 1'b0, "R5 ack held while strobe low", ack_w, 0);
    bus_end();
  endtask

  task automatic t_irq();
    hp_mask = 4'b0010;
    @(negedge clk); hp_src = 4'b0001;
    @(negedge clk); hp_src = 4'b0000;
    chk(hp_w === 1'b1, "R10 masked source", hp_w, 1);
    hp_src = 4'b0010;
    @(negedge clk); hp_src = 4'b0000;
    chk(hp_w === 1'b0, "R10 enabled source", hp_w, 0);
    hp_clr = 4'b0010;
    @(negedge clk); hp_clr = 4'b0000;
    chk(hp_w === 1'b1, "R10 clear", hp_w, 1);
    hp_mask = 4'b0001;
    #1;
    chk(hp_w === 1'b0, "R10 sticky kept while masked", hp_w, 0);
    hp_clr = 4'b1111; hp_mask = 4'b0000; ps_mask = 2'b11;
    @(negedge clk); hp_clr = 4'b0000; ps_src = 2'b10;
    @(negedge clk); ps_src = 2'b00;
    chk(ps_w === 1'b0 && hp_w === 1'b1 && lp_w === 1'b1, "R10 group separation",
        {ps_w, hp_w, lp_w}, 3'b011);
    ps_clr = 2'b11;
    @(negedge clk); ps_clr = 2'b00;
    chk(ps_w === 1'b1, "R10 ps clear", ps_w, 1);
  endtask

  initial begin
    rst_n = 1'b0; async_mode = 1'b0;
    bus_addr = '0; bus_as_n = 1'b1; bus_ds_n = 1'b1; bus_rw_n = 1'b1;
    bus_data_in = '0; bus_par_in = '0;
    hp_src = '0; hp_mask = '0; hp_clr = '0;
    lp_src = '0; lp_mask = '0; lp_clr = '0;
    ps_src = '0; ps_mask = '0; ps_clr = '0;
    par_err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read(1'b0, 0, 21'h1A_BCDE);
    t_read(1'b0, 3, 21'h00_00FF);
    t_read(1'b1, 0, 21'h15_5555);
    t_read(1'b1, 2, 21'h0A_8001);
    t_write_good(0, 21'h00_0010, 16'hBEEF);
    t_write_good(2, 21'h1F_FFFE, 16'h0180);
    t_write_bad();
    t_hold();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule